// File: doc/BRIEF.md
# Stream Backpressure Watchdog Timer

This block watches one DMA channel's outgoing stream for stalls. It looks at two status inputs. The first says that transfer work is still outstanding. The second says that the downstream sink can take data this cycle. While work is outstanding, the watchdog is enabled and the sink refuses data, the block runs a one-shot countdown. A programmable prescaler divides the clock by (prescale + 1) to make the countdown tick. When the countdown runs out, the block emits a single-cycle timeout event for the interrupt logic that sits outside it.

Any sign of progress disarms the timer at once: the sink accepting data, the work running out, or software clearing the enable. The next stall then starts a fresh, full-length countdown. The count and prescale settings come in as plain register-field inputs and are captured when the timer arms.

Top module: `bpto_timer`

## Requirements
- R1: After reset, `timeout_evt` and `timer_active` are both 0.
- R2: The timer arms only when `enable`=1, `work_pending`=1 and `sink_ready`=0 all hold at a clock edge. `timer_active` is 1 in the cycles after such an edge and 0 after any edge where the condition is false.
- R3: The prescaler restarts from zero on arming. One countdown tick happens every (prescale+1) clocks. With count value N≥1, `timeout_evt` is high in the cycle that follows edge number N·(prescale+1) after the arming edge, where the arming edge is number 0.
- R4: A count value of 0 behaves like 1: the event follows the first tick, (prescale+1) edges after arming.
- R5: The timer is one-shot. After the event, while the arming condition stays true, `timer_active` is 0 and no further event occurs. A new countdown starts only after the condition has been false for at least one edge.
- R6: `sink_ready`=1 at any edge cancels a running countdown without an event. Re-arming afterwards takes the full duration again.
- R7: Clearing `enable` cancels a running countdown, and no event is ever raised while `enable` was 0 at the expiring edge.
- R8: Dropping `work_pending` cancels a running countdown without an event.
- R9: `timeout_evt` is high for exactly one cycle per expiry.
- R10: `count_val` and `prescale` are captured at the arming edge. Changes to them while the timer runs do not move the expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Watchdog enable field |
| count_val | input | CNT_W (12) | Timeout count field |
| prescale | input | PRE_W (12) | Prescaler field; tick period is prescale+1 clocks |
| work_pending | input | 1 | Channel still has length remaining |
| sink_ready | input | 1 | Downstream stream can accept data |
| timer_active | output | 1 | Countdown is running |
| timeout_evt | output | 1 | One-cycle stream-timeout event |

## Verification
Random pairs of count and prescale values, including count 0 and prescale 0, measure the exact edge at which the event appears. This separates a correct tick spacing from an off-by-one in either the prescaler or the down-counter. Directed stalls are broken by `sink_ready`, by dropping `work_pending` and by clearing `enable`, one cause at a time. Each break must end the countdown without an event and must lead to a full-length re-arm. A held stall after expiry shows the timer is one-shot, and changing the settings mid-count shows they were captured at arming.

// File: rtl/bpto_pkg.sv
package bpto_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_SPENT = 2'd2
  } bpto_state_e;

  // A countdown value of zero or one ends on the next tick.
  function automatic logic is_final(input logic [31:0] v);
    return (v <= 32'd1);
  endfunction

  // Number of clock edges from arming to the expiring edge.
  function automatic int unsigned edges_to_expiry(input int unsigned cnt,
                                                  input int unsigned pre);
    int unsigned n;
    n = (cnt == 0) ? 1 : cnt;
    return n * (pre + 1);
  endfunction

endpackage

// File: rtl/bpto_prescaler.sv
module bpto_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);
  logic [PRE_W-1:0] phase_q;

  assign tick = run && (phase_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      phase_q <= '0;
    end else if (run) begin
      phase_q <= tick ? '0 : phase_q + 1'b1;
    end
  end

  // R3: with a divider above one, ticks never come back to back
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && limit != '0 && !clear) |=> !tick);

endmodule

// File: rtl/bpto_downcount.sv
module bpto_downcount #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  import bpto_pkg::*;

  logic [CNT_W-1:0] remain_q;

  assign last = is_final(32'(remain_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (dec && !last) begin
      remain_q <= remain_q - 1'b1;
    end
  end

endmodule

// File: rtl/bpto_timer.sv
module bpto_timer #(
  parameter int CNT_W = 12,
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] count_val,
  input  logic [PRE_W-1:0] prescale,
  input  logic             work_pending,
  input  logic             sink_ready,
  output logic             timer_active,
  output logic             timeout_evt
);
  import bpto_pkg::*;

  bpto_state_e      state_q, state_d;
  logic [PRE_W-1:0] pre_q;
  logic             arm_cond;
  logic             start_w;
  logic             run_w;
  logic             tick_w;
  logic             last_w;
  logic             expire_w;
  logic             evt_q;

  // Stall seen: enabled, work outstanding, sink refusing data.
  assign arm_cond = enable && work_pending && !sink_ready;
  assign start_w  = (state_q == ST_IDLE) && arm_cond;
  assign run_w    = (state_q == ST_RUN) && arm_cond;
  assign expire_w = tick_w && last_w;

  bpto_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_w),
    .run   (run_w),
    .limit (pre_q),
    .tick  (tick_w)
  );

  bpto_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_w),
    .load_val (count_val),
    .dec      (tick_w),
    .last     (last_w)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (arm_cond) state_d = ST_RUN;
      ST_RUN: begin
        if (!arm_cond)     state_d = ST_IDLE;
        else if (expire_w) state_d = ST_SPENT;
      end
      ST_SPENT: if (!arm_cond) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pre_q   <= '0;
      evt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      evt_q   <= expire_w;
      if (start_w) pre_q <= prescale;
    end
  end

  assign timer_active = (state_q == ST_RUN);
  assign timeout_evt  = evt_q;

  // R2: no running countdown after an edge without a stall
  p_idle_unarmed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_cond |=> !timer_active);
  // R7: an event needs the enable at the expiring edge
  p_evt_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |-> $past(enable));
  // R9: single-cycle pulse
  p_evt_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> !timeout_evt);
  // R5: after expiry the timer is not running
  p_oneshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |-> !timer_active);
  // R6: progress at an edge never yields an event
  p_progress_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sink_ready |=> !timeout_evt);

endmodule

// File: tb/sim_bpto_timer.sv
`timescale 1ns/100ps
module sim_bpto_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [11:0] count_val = '0;
  logic [11:0] prescale = '0;
  logic        work_pending = 1'b0;
  logic        sink_ready = 1'b1;
  logic        timer_active;
  logic        timeout_evt;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bpto_timer u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .count_val(count_val),
    .prescale(prescale), .work_pending(work_pending), .sink_ready(sink_ready),
    .timer_active(timer_active), .timeout_evt(timeout_evt)
  );

  function automatic int expect_edges(int n, int p);
    return ((n < 1) ? 1 : n) * (p + 1);
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic stall();
    enable = 1'b1; work_pending = 1'b1; sink_ready = 1'b0;
  endtask

  // Run until the first event; returns edge index after arming edge, or -1.
  task automatic measure(int limit, output int got);
    got = -1;
    for (int k = 0; k <= limit; k++) begin
      @(posedge clk); @(negedge clk);
      if (timeout_evt && got < 0) got = k;
    end
  endtask

  // Wait n edges; count events seen.
  task automatic idle_cycles(int n, output int evts);
    evts = 0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
      if (timeout_evt) evts++;
    end
  endtask

  task automatic release_all();
    sink_ready = 1'b1; work_pending = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int got, ev, e, n, p, m;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    check("R1 evt", timeout_evt, 0);
    check("R1 active", timer_active, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 directed: N=3, P=2
    count_val = 12'd3; prescale = 12'd2; stall();
    @(posedge clk); @(negedge clk);
    check("R2 armed", timer_active, 1);
    measure(40, got);
    check("R3 expiry edge", got + 1, expect_edges(3, 2));
    // R5 one-shot: hold stall
    idle_cycles(30, ev);
    check("R5 no second event", ev, 0);
    check("R5 inactive", timer_active, 0);
    release_all();

    // R4: zero count, P=4
    count_val = 12'd0; prescale = 12'd4; stall();
    measure(40, got);
    check("R4 zero count", got, expect_edges(0, 4));
    release_all();

    // R3: prescale 0, count 1
    count_val = 12'd1; prescale = 12'd0; stall();
    measure(20, got);
    check("R3 minimal", got, expect_edges(1, 0));
    release_all();

    // R2: no arming without enable
    count_val = 12'd2; prescale = 12'd0; stall(); enable = 1'b0;
    idle_cycles(10, ev);
    check("R2 no enable evt", ev, 0);
    check("R2 no enable active", timer_active, 0);
    release_all();

    // R6: sink progress cancels, then full re-arm
    count_val = 12'd4; prescale = 12'd3; stall();
    idle_cycles(10, ev);
    sink_ready = 1'b1;
    idle_cycles(1, ev);
    check("R6 cancel active", timer_active, 0);
    sink_ready = 1'b0;
    measure(60, got);
    check("R6 full rearm", got, expect_edges(4, 3));
    release_all();

    // R7: enable cleared mid-count
    count_val = 12'd3; prescale = 12'd1; stall();
    idle_cycles(3, ev);
    enable = 1'b0;
    idle_cycles(20, ev);
    check("R7 no event", ev, 0);
    check("R7 inactive", timer_active, 0);
    release_all();

    // R8: work dropped mid-count
    count_val = 12'd3; prescale = 12'd1; stall();
    idle_cycles(3, ev);
    work_pending = 1'b0;
    idle_cycles(20, ev);
    check("R8 no event", ev, 0);
    check("R8 inactive", timer_active, 0);
    release_all();

    // R10: settings changed while running
    count_val = 12'd2; prescale = 12'd3; stall();
    @(posedge clk); @(negedge clk);
    count_val = 12'd9; prescale = 12'd0;
    measure(60, got);
    check("R10 captured", got + 1, expect_edges(2, 3));
    release_all();

    // R9: pulse width
    count_val = 12'd1; prescale = 12'd1; stall();
    measure(10, got);
    idle_cycles(0, ev);
    check("R9 pulse ends", timeout_evt, 0);
    release_all();

    // Random stalls, some interrupted (R3, R6)
    for (int i = 0; i < 24; i++) begin
      n = $urandom_range(12, 0);
      p = $urandom_range(6, 0);
      count_val = 12'(n); prescale = 12'(p);
      e = expect_edges(n, p);
      stall();
      if ($urandom_range(3, 0) == 0 && e > 2) begin
        m = $urandom_range(e - 2, 1);
        idle_cycles(m, ev);
        sink_ready = 1'b1;
        idle_cycles(1, ev);
        check("R6 random cancel", ev, 0);
        sink_ready = 1'b0;
      end
      measure(e + 4, got);
      check("R3 random expiry", got, e);
      release_all();
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule